// File: doc/BRIEF.md
# Event Combiner and Interrupt Mapper

This block takes 128 single-cycle system event pulses and turns them into twelve CPU interrupt pulses and one exception level. A pulse on an event line sets that event's sticky flag. The flag stays set until software clears it. Each CPU interrupt output follows one event chosen by a 7-bit selector, and it pulses once when that event goes active.

Four combiners each cover a group of 32 events. A combiner output is the OR of the flagged events in its group that are not masked. The four combiner outputs take the place of event numbers 0 to 3, so they can be selected like any other event. This lets a whole group of events share one CPU interrupt. A combiner never covers its own output. The exception output is the OR of all effective events enabled in a separate 128-bit enable set.

Software reaches the block through a synchronous word-addressed bus (32-bit data):

| Word address | Read | Write |
|---|---|---|
| 0–3 | effective events, 32 per word | 1 bits clear flags |
| 4–7 | combiner masks | combiner masks |
| 8–11 | exception enables | exception enables |
| 12–23 | selector for CPU interrupt 4 to 15 | selector |

Top module: `evtmap_top`

## Requirements
- R1: After reset:
  - all flags read 0;
  - every combiner mask bit reads 1 (masked);
  - exception enables and selectors read 0;
  - `int_o`, `exc_o` and `bus_rdata` are 0.
- R2: A pulse on a non-reserved event 4..127 sets its flag on that clock edge. The flag reads back as bit (n mod 32) of word n/32 and stays set.
- R3: Raw inputs 0..3 and the reserved numbers never set a flag. The reserved numbers are 4–8, 19, 23, 25–31, 34, 35 and 37–39.
- R4: Writing word 0..3 clears each flag whose data bit is 1 and leaves the others as they are. If an event pulse and its clear fall in the same cycle, the flag stays set.
- R5: Combiner c drives event c. It is the OR of the flags in events 32c..32c+31 whose mask bit is 0. A mask bit of 1 excludes the event. Its value reads as bit c of word 0.
- R6: `int_o[j]` (CPU interrupt j+4) is high for exactly one cycle. It rises one clock after the edge at which its selected effective event goes from 0 to 1.
- R7: A selector holding 0..3 makes its interrupt pulse when that combiner output rises. This includes a rise caused by unmasking an event that is already flagged.
- R8: `exc_o` is registered. One clock after any state change, it equals the OR of the effective events whose exception enable bit is 1.
- R9: A read returns the addressed word on `bus_rdata` one clock later. Unmapped addresses 24..31 return 0. `bus_rdata` holds its value while no read is issued.
- R10: A selector write keeps only `bus_wdata[6:0]`. The upper bits read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_in | input | 128 | System event pulses |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read |
| int_o | output | 12 | CPU interrupt pulses, bit j is interrupt j+4 |
| exc_o | output | 1 | Exception level |

## Verification
- **Flags and reads:** An event or clear sampled at edge k changes the flag state at k, and a read issued at edge k is on `bus_rdata` after k.
- **Interrupts and exception:** `int_o` and `exc_o` carry one more register, so they react at edge k+1 to a flag, mask, enable or selector change made at edge k.
- **Reference model:** The bench's model keeps the same stage counts. It is compared with the outputs at every falling edge, away from the sampling edge.
- **Directed checks:** Each directed check waits the exact number of falling edges for its result before it samples.

// File: rtl/evtmap_pkg.sv
package evtmap_pkg;
    localparam int EVT_N   = 128;
    localparam int GRP_W   = 32;
    localparam int CMB_N   = EVT_N / GRP_W;
    localparam int INT_N   = 12;
    localparam int SEL_W   = $clog2(EVT_N);
    localparam int ADDR_W  = 5;
    // event numbers with no source attached
    localparam logic [EVT_N-1:0] RSV_DEFAULT =
        128'h0000_0000_0000_0000_0000_00EC_FE88_01F0;
endpackage

// File: rtl/evtmap_flags.sv
module evtmap_flags #(
    parameter int EVT_N = 128,
    parameter int GRP_W = 32,
    parameter logic [EVT_N-1:0] IGNORE = '0,
    localparam int WORDS = EVT_N / GRP_W,
    localparam int WI_W  = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_N-1:0] evt_i,
    input  logic             clr_en_i,
    input  logic [WI_W-1:0]  clr_word_i,
    input  logic [GRP_W-1:0] clr_bits_i,
    output logic [EVT_N-1:0] flags_o
);
    typedef struct packed {
        logic [EVT_N-1:0] flag;
    } flag_st_t;

    flag_st_t st_d, st_q;
    logic [EVT_N-1:0] clr;

    always_comb begin
        clr = '0;
        for (int w = 0; w < WORDS; w++) begin
            if (clr_en_i && (int'(clr_word_i) == w)) clr[w*GRP_W +: GRP_W] = clr_bits_i;
        end
        // set takes precedence over a clear in the same cycle
        st_d.flag = (st_q.flag & ~clr) | (evt_i & ~IGNORE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o = st_q.flag;
endmodule

// File: rtl/evtmap_combine.sv
module evtmap_combine #(
    parameter int EVT_N = 128,
    parameter int GRP_W = 32,
    localparam int CMB_N = EVT_N / GRP_W
) (
    input  logic [EVT_N-1:0] flags_i,
    input  logic [EVT_N-1:0] mask_i,
    output logic [CMB_N-1:0] cmb_o
);
    for (genvar c = 0; c < CMB_N; c++) begin : g_cmb
        assign cmb_o[c] = |(flags_i[c*GRP_W +: GRP_W] & ~mask_i[c*GRP_W +: GRP_W]);
    end
endmodule

// File: rtl/evtmap_regs.sv
module evtmap_regs #(
    parameter int EVT_N  = 128,
    parameter int GRP_W  = 32,
    parameter int INT_N  = 12,
    parameter int SEL_W  = 7,
    parameter int ADDR_W = 5,
    localparam int WORDS     = EVT_N / GRP_W,
    localparam int WI_W      = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int MASK_BASE = WORDS,
    localparam int EXC_BASE  = 2 * WORDS,
    localparam int SEL_BASE  = 3 * WORDS
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_i,
    input  logic                   rd_i,
    input  logic [ADDR_W-1:0]      addr_i,
    input  logic [GRP_W-1:0]       wdata_i,
    input  logic [EVT_N-1:0]       eff_i,
    output logic [GRP_W-1:0]       rdata_o,
    output logic [EVT_N-1:0]       mask_o,
    output logic [EVT_N-1:0]       exen_o,
    output logic [INT_N*SEL_W-1:0] sel_o,
    output logic                   clr_en_o,
    output logic [WI_W-1:0]        clr_word_o,
    output logic [GRP_W-1:0]       clr_bits_o
);
    typedef struct packed {
        logic [EVT_N-1:0]       mask;
        logic [EVT_N-1:0]       exen;
        logic [INT_N*SEL_W-1:0] sel;
        logic [GRP_W-1:0]       rdata;
    } reg_st_t;

    reg_st_t st_d, st_q;
    int      a;

    always_comb begin
        st_d = st_q;
        a    = int'(addr_i);
        if (wr_i) begin
            for (int w = 0; w < WORDS; w++) begin
                if (a == MASK_BASE + w) st_d.mask[w*GRP_W +: GRP_W] = wdata_i;
                if (a == EXC_BASE + w)  st_d.exen[w*GRP_W +: GRP_W] = wdata_i;
            end
            for (int j = 0; j < INT_N; j++) begin
                if (a == SEL_BASE + j) st_d.sel[j*SEL_W +: SEL_W] = wdata_i[SEL_W-1:0];
            end
        end
        if (rd_i) begin
            st_d.rdata = '0;
            for (int w = 0; w < WORDS; w++) begin
                if (a == w)             st_d.rdata = eff_i[w*GRP_W +: GRP_W];
                if (a == MASK_BASE + w) st_d.rdata = st_q.mask[w*GRP_W +: GRP_W];
                if (a == EXC_BASE + w)  st_d.rdata = st_q.exen[w*GRP_W +: GRP_W];
            end
            for (int j = 0; j < INT_N; j++) begin
                if (a == SEL_BASE + j) st_d.rdata = GRP_W'(st_q.sel[j*SEL_W +: SEL_W]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.mask  <= '1;
        end else begin
            st_q       <= st_d;
        end
    end

    assign rdata_o    = st_q.rdata;
    assign mask_o     = st_q.mask;
    assign exen_o     = st_q.exen;
    assign sel_o      = st_q.sel;
    assign clr_en_o   = wr_i && (int'(addr_i) < WORDS);
    assign clr_word_o = WI_W'(addr_i);
    assign clr_bits_o = wdata_i;
endmodule

// File: rtl/evtmap_route.sv
module evtmap_route #(
    parameter int EVT_N = 128,
    parameter int INT_N = 12,
    parameter int SEL_W = 7
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [EVT_N-1:0]       eff_i,
    input  logic [EVT_N-1:0]       exen_i,
    input  logic [INT_N*SEL_W-1:0] sel_i,
    output logic [INT_N-1:0]       irq_o,
    output logic                   exc_o
);
    typedef struct packed {
        logic [EVT_N-1:0] prev;
        logic [INT_N-1:0] irq;
        logic             exc;
    } route_st_t;

    route_st_t        st_d, st_q;
    logic [SEL_W-1:0] s;

    always_comb begin
        st_d = st_q;
        s    = '0;
        for (int j = 0; j < INT_N; j++) begin
            s = sel_i[j*SEL_W +: SEL_W];
            st_d.irq[j] = eff_i[s] & ~st_q.prev[s];
        end
        st_d.prev = eff_i;
        st_d.exc  = |(eff_i & exen_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = st_q.irq;
    assign exc_o = st_q.exc;
endmodule

// File: rtl/evtmap_top.sv
module evtmap_top
    import evtmap_pkg::*;
#(
    parameter logic [EVT_N-1:0] RSV_EVT = RSV_DEFAULT,
    localparam int WI_W = (CMB_N > 1) ? $clog2(CMB_N) : 1,
    localparam logic [EVT_N-1:0] IGNORE = RSV_EVT | EVT_N'((1 << CMB_N) - 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [EVT_N-1:0]  evt_in,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [GRP_W-1:0]  bus_wdata,
    output logic [GRP_W-1:0]  bus_rdata,
    output logic [INT_N-1:0]  int_o,
    output logic              exc_o
);
    logic [EVT_N-1:0]       flags, mask, exen, eff;
    logic [CMB_N-1:0]       cmb;
    logic [INT_N*SEL_W-1:0] sel;
    logic                   clr_en;
    logic [WI_W-1:0]        clr_word;
    logic [GRP_W-1:0]       clr_bits;

    evtmap_flags #(.EVT_N(EVT_N), .GRP_W(GRP_W), .IGNORE(IGNORE)) u_flags (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_in), .clr_en_i(clr_en),
        .clr_word_i(clr_word), .clr_bits_i(clr_bits), .flags_o(flags));

    evtmap_combine #(.EVT_N(EVT_N), .GRP_W(GRP_W)) u_cmb (
        .flags_i(flags), .mask_i(mask), .cmb_o(cmb));

    // combiner outputs occupy the lowest event numbers
    assign eff = {flags[EVT_N-1:CMB_N], cmb};

    evtmap_regs #(.EVT_N(EVT_N), .GRP_W(GRP_W), .INT_N(INT_N), .SEL_W(SEL_W),
                  .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_i(bus_wr), .rd_i(bus_rd), .addr_i(bus_addr),
        .wdata_i(bus_wdata), .eff_i(eff), .rdata_o(bus_rdata), .mask_o(mask),
        .exen_o(exen), .sel_o(sel), .clr_en_o(clr_en), .clr_word_o(clr_word),
        .clr_bits_o(clr_bits));

    evtmap_route #(.EVT_N(EVT_N), .INT_N(INT_N), .SEL_W(SEL_W)) u_route (
        .clk(clk), .rst_n(rst_n), .eff_i(eff), .exen_i(exen), .sel_i(sel),
        .irq_o(int_o), .exc_o(exc_o));
endmodule

// File: rtl/evtmap_chk.sv
module evtmap_chk
    import evtmap_pkg::*;
#(
    parameter logic [EVT_N-1:0] IGNORE = RSV_DEFAULT | EVT_N'((1 << CMB_N) - 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [EVT_N-1:0] evt_in,
    input logic             bus_rd,
    input logic [GRP_W-1:0] bus_rdata,
    input logic [INT_N-1:0] int_o,
    input logic             exc_o,
    input logic [EVT_N-1:0] flags,
    input logic [EVT_N-1:0] eff
);
    logic armed;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    a_r3_rsv_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (flags & IGNORE) == '0);

    a_r2_set_sticky: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (($past(evt_in) & ~IGNORE) & ~flags) == '0);

    a_r8_exc_cause: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        exc_o |-> ($past(eff) != '0));

    a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        !$past(bus_rd) |-> $stable(bus_rdata));

    for (genvar j = 0; j < INT_N; j++) begin : g_int
        a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
            int_o[j] |=> !int_o[j]);
        a_r6_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n || !armed)
            int_o[j] |-> ($past(eff) != '0));
    end
endmodule

bind evtmap_top evtmap_chk u_chk (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .int_o(int_o), .exc_o(exc_o), .flags(flags), .eff(eff));

// File: tb/tb_evtmap_top.sv
module tb_evtmap_top;
    localparam int CLK_P = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [127:0] evt_in = '0;
    logic         bus_wr = 1'b0, bus_rd = 1'b0;
    logic [4:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [11:0]  int_o;
    logic         exc_o;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    evtmap_top dut (.clk(clk), .rst_n(rst_n), .evt_in(evt_in), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .int_o(int_o), .exc_o(exc_o));

    always #(CLK_P/2) clk = ~clk;

    function automatic bit is_rsv(int i);
        return (i < 4) || (i >= 4 && i <= 8) || i == 19 || i == 23 ||
               (i >= 25 && i <= 31) || i == 34 || i == 35 || (i >= 37 && i <= 39);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // behavioural reference model
    logic [127:0] m_flag, m_mask, m_exen, m_prev;
    int           m_sel [12];
    logic [11:0]  m_int;
    logic         m_exc;
    logic [31:0]  m_rdata;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_flag = '0; m_mask = '1; m_exen = '0; m_prev = '0;
            for (int j = 0; j < 12; j++) m_sel[j] = 0;
            m_int = '0; m_exc = 1'b0; m_rdata = '0;
        end else begin
            logic [127:0] e, nf;
            int a;
            e = m_flag;
            for (int c = 0; c < 4; c++) begin
                e[c] = 1'b0;
                for (int i = c*32; i < c*32 + 32; i++)
                    if (i >= 4 && m_flag[i] && !m_mask[i]) e[c] = 1'b1;
            end
            for (int j = 0; j < 12; j++) m_int[j] = e[m_sel[j]] && !m_prev[m_sel[j]];
            m_exc  = |(e & m_exen);
            m_prev = e;
            a = int'(bus_addr);
            if (bus_rd) begin
                m_rdata = '0;
                if (a < 4)       m_rdata = e[a*32 +: 32];
                else if (a < 8)  m_rdata = m_mask[(a-4)*32 +: 32];
                else if (a < 12) m_rdata = m_exen[(a-8)*32 +: 32];
                else if (a < 24) m_rdata = 32'(m_sel[a-12]);
            end
            nf = m_flag;
            if (bus_wr && a < 4)
                for (int b = 0; b < 32; b++) if (bus_wdata[b]) nf[a*32+b] = 1'b0;
            for (int i = 0; i < 128; i++) if (evt_in[i] && !is_rsv(i)) nf[i] = 1'b1;
            m_flag = nf;
            if (bus_wr) begin
                if (a >= 4 && a < 8)        m_mask[(a-4)*32 +: 32] = bus_wdata;
                else if (a >= 8 && a < 12)  m_exen[(a-8)*32 +: 32] = bus_wdata;
                else if (a >= 12 && a < 24) m_sel[a-12] = int'(bus_wdata[6:0]);
            end
        end
    end

    // compare on every cycle, away from the sampling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(int_o === m_int, "R6 int_o vs model", 128'(int_o), 128'(m_int));
            chk(exc_o === m_exc, "R8 exc_o vs model", 128'(exc_o), 128'(m_exc));
            chk(bus_rdata === m_rdata, "R9 rdata vs model", 128'(bus_rdata), 128'(m_rdata));
        end
    end

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        step(); bus_wr = 1'b1; bus_addr = 5'(a); bus_wdata = d;
        step(); bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        step(); bus_rd = 1'b1; bus_addr = 5'(a);
        step(); bus_rd = 1'b0; d = bus_rdata;
    endtask

    task automatic pulse(input int n);
        step(); evt_in = '0; evt_in[n] = 1'b1;
        step(); evt_in = '0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_P * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset contents
        chk(int_o == 0 && exc_o == 0, "R1 outputs after reset", {int_o, exc_o}, 0);
        for (int a = 0; a < 24; a++) begin
            rd(a, d);
            chk(d == ((a >= 4 && a < 8) ? 32'hFFFF_FFFF : 32'h0), "R1 reset word", d,
                (a >= 4 && a < 8) ? 32'hFFFF_FFFF : 32'h0);
        end
        // R3: reserved numbers and raw 0..3 leave no flag
        pulse(5); pulse(19); pulse(2); pulse(0); pulse(38);
        rd(0, d); chk(d == 0, "R3 reserved word0", d, 0);
        rd(1, d); chk(d == 0, "R3 reserved word1", d, 0);
        // R10: selector width
        wr(12, 32'hFFFF_FF28);
        rd(12, d); chk(d == 32'h28, "R10 selector readback", d, 32'h28);
        // R6: pulse timing on interrupt 4 selecting event 40
        pulse(40);
        step(); chk(int_o == 12'h001, "R6 pulse at k+1", int_o, 12'h001);
        step(); chk(int_o == 12'h000, "R6 pulse one cycle", int_o, 0);
        // R2: sticky flag
        rd(1, d); chk(d == 32'h100, "R2 flag 40 sticky", d, 32'h100);
        // R7: combiner 1 rising by unmasking a flagged event
        wr(13, 32'd1);
        wr(5, ~32'h100);
        step(); chk(int_o == 12'h002, "R7 combiner pulse", int_o, 12'h002);
        // R5: combined bits in word 0
        rd(0, d); chk(d == 32'h2, "R5 combiner readback", d, 32'h2);
        // R8: exception enable
        wr(9, 32'h100);
        step(); chk(exc_o == 1'b1, "R8 exc high", exc_o, 1);
        // R4: clear
        wr(1, 32'h100);
        step(); chk(exc_o == 1'b0, "R8 exc low after clear", exc_o, 0);
        rd(1, d); chk(d == 0, "R4 cleared", d, 0);
        rd(0, d); chk(d == 0, "R5 combiner drops", d, 0);
        // R4: same-cycle set and clear
        step(); evt_in[100] = 1'b1; bus_wr = 1'b1; bus_addr = 5'd3; bus_wdata = 32'h10;
        step(); evt_in = '0; bus_wr = 1'b0;
        rd(3, d); chk(d == 32'h10, "R4 set wins", d, 32'h10);
        repeat (3) step();
        chk(bus_rdata == 32'h10, "R9 rdata holds", bus_rdata, 32'h10);
        wr(3, 32'h10);
        rd(3, d); chk(d == 0, "R4 clear alone", d, 0);
        rd(30, d); chk(d == 0, "R9 unmapped", d, 0);
        // mixed traffic, model compared every cycle (R2 R5 R6 R7 R8 R9)
        for (int n = 0; n < 4000; n++) begin
            step();
            evt_in = '0;
            if ($urandom_range(0, 3) == 0) evt_in[$urandom_range(0, 127)] = 1'b1;
            bus_wr = ($urandom_range(0, 5) == 0);
            bus_rd = !bus_wr && ($urandom_range(0, 2) == 0);
            bus_addr = 5'($urandom_range(0, 31));
            bus_wdata = $urandom();
            if (bus_wr && bus_addr >= 12 && $urandom_range(0, 1) == 0)
                bus_wdata = 32'($urandom_range(0, 7));
        end
        step(); evt_in = '0; bus_wr = 1'b0; bus_rd = 1'b0;
        repeat (3) step();
        finish_run();
    end
endmodule